// File: doc/BRIEF.md
# Status-Flag ALU with Branch Predicates

This block is the arithmetic and logic stage of a 16-bit processor that can also work on bytes. Given two operands, an operation select, a byte/word select and the current status word, it returns the result and a flag telling the register file whether to store it. It computes the V, N, Z and C flags for the next status word and captures that word in a register when `issue` is high.

Alongside the ALU, the block evaluates one of eight branch conditions against the incoming status word. The processor's sequencer can then decide a conditional jump in the same cycle. Operand fetch and addressing are handled elsewhere. The block sees only the operand values.

Top module: `flag_alu`

## Requirements
- R1: The status word places C at bit 0, Z at bit 1, N at bit 2 and V at bit 8. While `issue` is high, `sr_out` loads `sr_in` at the clock edge, with those four bits replaced when the operation updates flags. All other bits pass through unchanged. Without `issue`, `sr_out` holds its value. Reset clears it to zero.
- R2: Op 0 (add) and op 1 (add plus carry-in C) produce the sum at the active width. C is the carry out of that width. V is set when the signed sum does not fit. N is the result MSB at that width. Z is set when the result is zero.
- R3: Op 2 (subtract) computes a + ~b + 1. Op 3 (subtract with borrow) computes a + ~b + C. Carry, V, N and Z follow the rules of R2.
- R4: Op 4 (compare) sets the flags exactly as op 2 does, and `wr_en` is 0.
- R5: When `byte_sel` is 1, both operands are cut to 8 bits, the flags use width 8, and result[15:8] is 0. Ops 13 and 14 are excepted: they always work on 16 bits.
- R6: Op 6 (AND) and op 7 (bit test, AND without writing) set N and Z from the result. They set C to "result nonzero" and clear V. Op 7 drives `wr_en` 0.
- R7: Op 8 (a AND NOT b) and op 9 (a OR b) write their result and leave all flags unchanged.
- R8: Op 10 (XOR) sets N and Z from the result and sets C to "result nonzero". V is set only when both operands have the sign bit set.
- R9: Op 5 (decimal add) treats each operand as packed decimal, 2 digits in byte mode and 4 in word mode, where each nibble carries its decimal weight. It adds them together with C. C is set when the sum exceeds 99 (byte) or 9999 (word). The result is the sum re-packed as decimal digits at that width. N and Z come from the result, and V is cleared.
- R10: Op 11 (rotate right through carry) shifts operand a right, puts the old C into the MSB and the old LSB into C. Op 12 (arithmetic right shift) keeps the sign bit and puts the old LSB into C. Both clear V and set N and Z from the result.
- R11: Op 13 (byte swap) exchanges the two bytes of a and leaves the flags unchanged. Op 14 (sign extend) copies a[7] into bits 15:8, sets N and Z at 16 bits, sets C to "result nonzero" and clears V.
- R12: `jump_taken` reflects `cond`, evaluated on `sr_in`: 0 Z=0, 1 Z=1, 2 C=0, 3 C=1, 4 N=1, 5 N equal to V, 6 N differs from V, 7 always.
- R13: Op 15 is reserved. It drives `wr_en` 0 and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Capture the updated status word at the next edge |
| op | input | 4 | Operation select |
| byte_sel | input | 1 | 1 = byte width, 0 = word width |
| op_a | input | 16 | First operand (destination / single operand) |
| op_b | input | 16 | Second operand (source) |
| sr_in | input | 16 | Current status word |
| cond | input | 3 | Branch condition select |
| result | output | 16 | Operation result |
| wr_en | output | 1 | Result is to be stored |
| sr_out | output | 16 | Registered updated status word |
| jump_taken | output | 1 | Selected branch condition is true |

## Verification
The clocked assertions assume that `op_a`, `op_b`, `byte_sel` and `sr_in` remain at the values they had during the `issue` cycle until that edge has been sampled. They compare the registered status word against those earlier inputs. The bench meets this by changing inputs only on falling edges and holding them for a whole cycle after each issue. Random operands are drawn over the full 16-bit range; for decimal add, this includes nibbles above 9. Directed cases cover the carry and overflow edges, the two decimal-carry thresholds and the reserved opcode.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [3:0]   op,
  input  logic         byte_sel,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] sr_in,
  input  logic [2:0]   cond,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [W-1:0] sr_out,
  output logic         jump_taken
);
  localparam int HB = W / 2;
  localparam logic [3:0] O_ADD = 4'd0, O_ADDC = 4'd1, O_SUB = 4'd2, O_SUBC = 4'd3,
                         O_CMP = 4'd4, O_DADD = 4'd5, O_AND = 4'd6, O_BIT = 4'd7,
                         O_BIC = 4'd8, O_BIS = 4'd9, O_XOR = 4'd10, O_RRC = 4'd11,
                         O_RRA = 4'd12, O_SWPB = 4'd13, O_SXT = 4'd14;

  logic         wide, narrow, c_in;
  logic [W-1:0] mask, a, b, bb, r, r_m, sr_next;
  logic [W:0]   sum;
  logic         cin, upd, fv, fc, fn, fz, a_top, bb_top, r_top;
  logic [W-1:0] bin, dg0, dg1, dg2, dg3;
  logic [W-1:0] sr_q;

  assign wide   = (op == O_SWPB) || (op == O_SXT);
  assign narrow = byte_sel && !wide;
  assign mask   = narrow ? {{HB{1'b0}}, {HB{1'b1}}} : '1;
  assign a      = op_a & mask;
  assign b      = op_b & mask;
  assign c_in   = sr_in[0];

  assign bb  = (op == O_SUB || op == O_SUBC || op == O_CMP) ? (~b & mask) : b;
  assign cin = (op == O_ADD) ? 1'b0 : (op == O_SUB || op == O_CMP) ? 1'b1 : c_in;
  assign sum = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, cin};

  assign a_top  = narrow ? a[HB-1]  : a[W-1];
  assign bb_top = narrow ? bb[HB-1] : bb[W-1];

  assign bin = {12'd0, a[3:0]} + 16'd10 * {12'd0, a[7:4]} + 16'd100 * {12'd0, a[11:8]}
             + 16'd1000 * {12'd0, a[15:12]}
             + {12'd0, b[3:0]} + 16'd10 * {12'd0, b[7:4]} + 16'd100 * {12'd0, b[11:8]}
             + 16'd1000 * {12'd0, b[15:12]} + {15'd0, c_in};
  assign dg0 = bin % 16'd10;
  assign dg1 = (bin / 16'd10) % 16'd10;
  assign dg2 = (bin / 16'd100) % 16'd10;
  assign dg3 = (bin / 16'd1000) % 16'd10;

  always_comb begin
    r     = '0;
    wr_en = 1'b1;
    upd   = 1'b1;
    fv    = 1'b0;
    fc    = 1'b0;
    case (op)
      O_ADD, O_ADDC, O_SUB, O_SUBC, O_CMP: begin
        r     = sum[W-1:0];
        fc    = narrow ? sum[HB] : sum[W];
        fv    = (a_top == bb_top) && ((narrow ? sum[HB-1] : sum[W-1]) != a_top);
        wr_en = (op != O_CMP);
      end
      O_DADD: begin
        r  = {dg3[3:0], dg2[3:0], dg1[3:0], dg0[3:0]};
        fc = narrow ? (bin > 16'd99) : (bin > 16'd9999);
      end
      O_AND, O_BIT: begin
        r     = a & b;
        fc    = |r;
        wr_en = (op == O_AND);
      end
      O_BIC: begin r = a & ~b; upd = 1'b0; end
      O_BIS: begin r = a | b;  upd = 1'b0; end
      O_XOR: begin
        r  = a ^ b;
        fc = |r;
        fv = a_top && (narrow ? b[HB-1] : b[W-1]);
      end
      O_RRC: begin
        r  = (a >> 1) | (c_in ? (narrow ? W'(1) << (HB-1) : W'(1) << (W-1)) : '0);
        fc = a[0];
      end
      O_RRA: begin
        r  = (a >> 1) | (a_top ? (narrow ? W'(1) << (HB-1) : W'(1) << (W-1)) : '0);
        fc = a[0];
      end
      O_SWPB: begin r = {a[HB-1:0], a[W-1:HB]}; upd = 1'b0; end
      O_SXT: begin
        r  = {{HB{a[HB-1]}}, a[HB-1:0]};
        fc = |r;
      end
      default: begin wr_en = 1'b0; upd = 1'b0; end
    endcase
  end

  assign r_m    = r & mask;
  assign r_top  = narrow ? r_m[HB-1] : r_m[W-1];
  assign fn     = r_top;
  assign fz     = (r_m == '0);
  assign result = r_m;

  assign sr_next = upd ? {sr_in[W-1:9], fv, sr_in[7:3], fn, fz, fc} : sr_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     sr_q <= '0;
    else if (issue) sr_q <= sr_next;
  assign sr_out = sr_q;

  always_comb
    case (cond)
      3'd0: jump_taken = !sr_in[1];
      3'd1: jump_taken = sr_in[1];
      3'd2: jump_taken = !sr_in[0];
      3'd3: jump_taken = sr_in[0];
      3'd4: jump_taken = sr_in[2];
      3'd5: jump_taken = (sr_in[2] == sr_in[8]);
      3'd6: jump_taken = (sr_in[2] != sr_in[8]);
      default: jump_taken = 1'b1;
    endcase

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(sr_out));
  // R1
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (sr_out[7:3] == $past(sr_in[7:3])) && (sr_out[15:9] == $past(sr_in[15:9])));
  // R4
  cmp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op == O_CMP |=> sr_out[1] == ($past(byte_sel) ? ($past(op_a[7:0]) == $past(op_b[7:0]))
                                                          : ($past(op_a) == $past(op_b))));
  // R6
  and_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (op == O_AND || op == O_BIT) |=> (sr_out[0] == !sr_out[1]) && !sr_out[8]);
  // R7
  keep_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (op == O_BIC || op == O_BIS || op == O_SWPB || op == 4'd15) |=> sr_out == $past(sr_in));
  // R10
  rrc_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (op == O_RRC || op == O_RRA) |=> sr_out[0] == $past(op_a[0]));
  // R5
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sel && op != O_SWPB && op != O_SXT |-> result[15:8] == 8'h00);
endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;
  logic        clk = 0, rst_n = 0, issue = 0, byte_sel = 0;
  logic [3:0]  op = 0;
  logic [15:0] op_a = 0, op_b = 0, sr_in = 0;
  logic [2:0]  cond = 0;
  logic [15:0] result, sr_out;
  logic        wr_en, jump_taken;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  flag_alu uut (.clk, .rst_n, .issue, .op, .byte_sel, .op_a, .op_b, .sr_in, .cond,
                .result, .wr_en, .sr_out, .jump_taken);

  function automatic string tag_of(input int o);
    case (o)
      0, 1: return "R2";  2, 3: return "R3";  4: return "R4";  5: return "R9";
      6, 7: return "R6";  8, 9: return "R7";  10: return "R8";
      11, 12: return "R10"; 13, 14: return "R11"; default: return "R13";
    endcase
  endfunction

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  function automatic void model(input int o, input bit bs, input int a0, input int b0,
                                input int s, output int r, output bit wr, output int snew);
    bit wd = (o == 13 || o == 14);
    int w = (bs && !wd) ? 8 : 16;
    int mask = (1 << w) - 1, msb = 1 << (w - 1);
    int a = a0 & mask, b = b0 & mask, c = s & 1;
    bit upd = 1, v = 0, cf = 0;
    int sa, sb, sres, cin, bin, nd, p;
    wr = 1; r = 0;
    sa = (a & msb) ? a - (mask + 1) : a;
    sb = (b & msb) ? b - (mask + 1) : b;
    case (o)
      0, 1: begin
        cin = (o == 1) ? c : 0;
        r = (a + b + cin) & mask; cf = (a + b + cin) > mask;
        sres = sa + sb + cin; v = (sres > msb - 1) || (sres < -msb);
      end
      2, 3, 4: begin
        cin = (o == 3) ? c : 1;
        r = (a + (~b & mask) + cin) & mask; cf = (a + (~b & mask) + cin) > mask;
        sres = sa - sb + cin - 1; v = (sres > msb - 1) || (sres < -msb);
        wr = (o != 4);
      end
      5: begin
        nd = (w == 8) ? 2 : 4; bin = c; p = 1;
        for (int k = 0; k < nd; k++) begin
          bin += (((a >> (4*k)) & 15) + ((b >> (4*k)) & 15)) * p; p *= 10;
        end
        cf = bin > p - 1; p = 1;
        for (int k = 0; k < nd; k++) begin r |= ((bin / p) % 10) << (4*k); p *= 10; end
      end
      6, 7: begin r = a & b; cf = r != 0; wr = (o == 6); end
      8: begin r = a & ~b & mask; upd = 0; end
      9: begin r = a | b; upd = 0; end
      10: begin r = a ^ b; cf = r != 0; v = (a & msb) && (b & msb); end
      11: begin r = (a >> 1) | (c ? msb : 0); cf = a & 1; end
      12: begin r = (a >> 1) | (a & msb); cf = a & 1; end
      13: begin r = ((a >> 8) & 255) | ((a & 255) << 8); upd = 0; end
      14: begin r = (a & 128) ? (a | 16'hFF00) : (a & 255); cf = r != 0; end
      default: begin wr = 0; upd = 0; end
    endcase
    if (upd)
      snew = (s & ~32'h0107) | (int'(v) << 8) | (((r & msb) != 0) << 2) | ((r == 0) << 1) | int'(cf);
    else snew = s;
  endfunction

  function automatic bit jref(input int cd, input int s);
    bit z = s[1], cc = s[0], n = s[2], v = s[8];
    case (cd)
      0: return !z; 1: return z; 2: return !cc; 3: return cc;
      4: return n; 5: return n == v; 6: return n != v; default: return 1;
    endcase
  endfunction

  task automatic run(input int o, input bit bs, input int a, input int b, input int s, input int cd);
    int r, sn; bit wr;
    op = 4'(o); byte_sel = bs; op_a = 16'(a); op_b = 16'(b); sr_in = 16'(s); cond = 3'(cd);
    issue = 1;
    model(o, bs, a & 16'hFFFF, b & 16'hFFFF, s & 16'hFFFF, r, wr, sn);
    #2;
    chk({tag_of(o), " result"}, result, r);
    chk({tag_of(o), " wr_en"}, wr_en, wr);
    chk("R12 jump", jump_taken, jref(cd, s & 16'hFFFF));
    @(negedge clk);
    issue = 0;
    chk({tag_of(o), " R1 status"}, sr_out, sn);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd2024));
    #12 chk("R1 reset", sr_out, 0);
    @(negedge clk); rst_n = 1;
    // R2 directed
    run(0, 0, 16'h7FFF, 1, 0, 5);
    run(0, 0, 16'hFFFF, 1, 0, 0);
    run(1, 1, 16'h00FF, 0, 1, 3);
    // R3
    run(2, 0, 0, 1, 0, 2);
    run(3, 0, 16'h8000, 1, 0, 6);
    // R4
    run(4, 0, 16'h1234, 16'h1234, 16'hA5A0, 1);
    // R5
    run(0, 1, 16'hAB80, 16'hCD80, 0, 4);
    // R9 thresholds
    run(5, 1, 16'h0099, 16'h0001, 0, 7);
    run(5, 0, 16'h9999, 16'h0000, 1, 7);
    run(5, 0, 16'h4999, 16'h5000, 0, 7);
    // R8
    run(10, 0, 16'h8000, 16'h8001, 0, 0);
    // R10
    run(11, 0, 16'h0001, 0, 1, 3);
    run(12, 1, 16'h0081, 0, 0, 4);
    // R11
    run(13, 1, 16'h12F0, 0, 16'h0107, 0);
    run(14, 0, 16'h0080, 0, 0, 4);
    // R13
    run(15, 0, 16'h1111, 16'h2222, 16'h0005, 1);
    // R1 hold without issue
    held = sr_out;
    op = 0; op_a = 16'hFFFF; op_b = 16'h0001; sr_in = 16'hFFFF;
    @(negedge clk);
    chk("R1 hold", sr_out, held);
    for (int i = 0; i < 3000; i++)
      run($urandom_range(0, 15), $urandom_range(0, 1), $urandom, $urandom, $urandom,
          $urandom_range(0, 7));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule